// File: doc/BRIEF.md
# Generalized bit-reverse permuter

This unit rearranges the bits of a 64-bit operand `ra` under the control of a small index taken from `rb`. Result bit `i` is copied from operand bit `i XOR k`, where `k` is the control value. One control value therefore picks a whole family of swap patterns. `k = 0` is the identity. `k = 7` reverses the bits inside every byte, `k = 56` swaps the byte order, and `k = 4` exchanges the nibbles of every byte. A control of all ones reverses the operand end to end.

The unit has two widths. In full-width mode the control is the low six bits of `rb` and all 64 result bits are permuted. In half-width mode only the low five bits of `rb` count, the low 32 bits are permuted among themselves, and the upper 32 result bits are cleared. The permutation is a network of log2(width) butterfly stages. Stage `s` exchanges neighbouring groups of `2^s` bits when control bit `s` is set. The result is registered once, so it appears on the clock edge after its operands. The two carry outputs are always zero.

Top module: `gbr_permuter`

## Requirements
- R1: With `half_mode` = 0, result bit i (0..63) equals `ra[i ^ rb[5:0]]`.
- R2: With `half_mode` = 1, result bit i (0..31) equals `ra[i ^ rb[4:0]]`.
- R3: With `half_mode` = 1, result bits 63..32 are zero.
- R4: Both bits of `carry` are 0 at all times.
- R5: Bits of `rb` above the control field are ignored: `rb[63:6]` in full-width mode, and `rb[63:5]` in half-width mode (this includes `rb[5]`).
- R6: A control value of 0 returns the operand unchanged in full-width mode. In half-width mode it returns the low 32 bits unchanged with the upper half zero.
- R7: A control of all ones (63 full-width, 31 half-width) reverses the bit order within the active width.
- R8: The result register loads on every rising `clk` edge, with a latency of one cycle. While `rst_n` is low, `result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register loads on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears the result |
| ra | input | 64 | Operand whose bits are permuted |
| rb | input | 64 | Control source; only the low field is used |
| half_mode | input | 1 | 1 selects 32-bit operation, 0 selects 64-bit operation |
| result | output | 64 | Registered permuted operand |
| carry | output | 2 | Carry pair, held at zero |

## Verification
Two functions meet in the same cycle when half-width mode is selected and `rb[5]` is set. The sixth control bit must then be dropped, and the upper half must be cleared, on one edge. If the control bit leaked through, upper operand bits would move into the low half. The bench provokes this with operands whose two halves differ and `rb[5]` set, and it alternates the mode on consecutive cycles. Every cycle's result is compared with a behavioural per-bit model, so any mixing of the two halves or any stale upper half shows up.

// File: rtl/gbr_pkg.sv
package gbr_pkg;
    localparam int GBR_DATA_W  = 64;
    localparam int GBR_CARRY_W = 2;

    typedef enum logic {
        WIDTH_FULL = 1'b0,
        WIDTH_HALF = 1'b1
    } gbr_width_e;
endpackage

// File: rtl/gbr_stage.sv
// One butterfly level: exchanges neighbouring groups of DIST bits when swap is set.
module gbr_stage #(
    parameter int WIDTH = 64,
    parameter int DIST  = 1
) (
    input  logic [WIDTH-1:0] din,
    input  logic             swap,
    output logic [WIDTH-1:0] dout
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        localparam int PARTNER = i ^ DIST;
        assign dout[i] = swap ? din[PARTNER] : din[i];
    end
endmodule

// File: rtl/gbr_network.sv
// Chain of log2(WIDTH) butterfly stages; composed, bit i takes input bit i ^ ctl.
module gbr_network #(
    parameter int WIDTH = 64,
    parameter int CTL_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [CTL_W-1:0] ctl,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] lane [CTL_W+1];

    assign lane[0] = din;

    for (genvar s = 0; s < CTL_W; s++) begin : g_stage
        gbr_stage #(
            .WIDTH (WIDTH),
            .DIST  (1 << s)
        ) u_stage (
            .din  (lane[s]),
            .swap (ctl[s]),
            .dout (lane[s+1])
        );
    end

    assign dout = lane[CTL_W];
endmodule

// File: rtl/gbr_narrow.sv
// Width shaping: half-width mode keeps the low half and clears the rest.
module gbr_narrow #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] din,
    input  logic             half,
    output logic [WIDTH-1:0] dout
);
    localparam int HALF_W = WIDTH / 2;

    always_comb begin
        dout = din;
        if (half) begin
            dout[WIDTH-1:HALF_W] = '0;
        end
    end
endmodule

// File: rtl/gbr_permuter.sv
module gbr_permuter
    import gbr_pkg::*;
#(
    parameter int DATA_W  = GBR_DATA_W,
    parameter int CARRY_W = GBR_CARRY_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  ra,
    input  logic [DATA_W-1:0]  rb,
    input  logic               half_mode,
    output logic [DATA_W-1:0]  result,
    output logic [CARRY_W-1:0] carry
);
    localparam int CTL_W = $clog2(DATA_W);

    gbr_width_e       width_sel;
    logic [CTL_W-1:0] ctl;
    logic [DATA_W-1:0] permuted;
    logic [DATA_W-1:0] shaped;
    logic             unused_rb_hi;

    assign width_sel    = half_mode ? WIDTH_HALF : WIDTH_FULL;
    assign unused_rb_hi = ^rb[DATA_W-1:CTL_W];

    // Control field: the top control bit is dropped in half-width mode.
    always_comb begin
        ctl = rb[CTL_W-1:0];
        unique case (width_sel)
            WIDTH_HALF: ctl[CTL_W-1] = 1'b0;
            WIDTH_FULL: ctl          = rb[CTL_W-1:0];
            default:    ctl          = rb[CTL_W-1:0];
        endcase
    end

    gbr_network #(
        .WIDTH (DATA_W),
        .CTL_W (CTL_W)
    ) u_network (
        .din  (ra),
        .ctl  (ctl),
        .dout (permuted)
    );

    gbr_narrow #(
        .WIDTH (DATA_W)
    ) u_narrow (
        .din  (permuted),
        .half (width_sel == WIDTH_HALF),
        .dout (shaped)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
        end else begin
            result <= shaped;
        end
    end

    assign carry = '0;
endmodule

// File: rtl/gbr_permuter_chk.sv
module gbr_permuter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] ra,
    input logic [63:0] rb,
    input logic        half_mode,
    input logic [63:0] result,
    input logic [1:0]  carry
);
    function automatic logic [63:0] flip64(input logic [63:0] v);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) r[i] = v[63-i];
        return r;
    endfunction

    function automatic logic [31:0] flip32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    logic pick_full_bit0;
    logic pick_half_bit0;
    assign pick_full_bit0 = ra[rb[5:0]];
    assign pick_half_bit0 = ra[rb[4:0]];

    // R1
    full_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !half_mode |=> result[0] == $past(pick_full_bit0));

    // R2
    half_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_mode |=> result[0] == $past(pick_half_bit0));

    // R3
    half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_mode |=> result[63:32] == 32'h0);

    // R4
    carry_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry == 2'b00);

    // R6
    identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!half_mode && rb[5:0] == 6'd0) |=> result == $past(ra));

    // R7
    full_reverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!half_mode && rb[5:0] == 6'd63) |=> result == flip64($past(ra)));

    // R7
    half_reverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (half_mode && rb[4:0] == 5'd31) |=> result[31:0] == flip32($past(ra[31:0])));
endmodule

bind gbr_permuter gbr_permuter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ra        (ra),
    .rb        (rb),
    .half_mode (half_mode),
    .result    (result),
    .carry     (carry)
);

// File: tb/tb_gbr_permuter.sv
`timescale 1ns/1ps
module tb_gbr_permuter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] ra = 64'h0123_4567_89AB_CDEF;
    logic [63:0] rb = 64'h3F;
    logic        half_mode = 1'b0;
    logic [63:0] result;
    logic [1:0]  carry;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    gbr_permuter dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ra        (ra),
        .rb        (rb),
        .half_mode (half_mode),
        .result    (result),
        .carry     (carry)
    );

    // Behavioural model: per-bit index arithmetic, nothing structural.
    function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b, input logic h);
        logic [63:0] r;
        int k;
        int lim;
        k   = h ? int'(b[4:0]) : int'(b[5:0]);
        lim = h ? 32 : 64;
        r   = '0;
        for (int i = 0; i < lim; i++) r[i] = a[i ^ k];
        return r;
    endfunction

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge: drives, waits one cycle, compares.
    task automatic step(input string tag, input logic [63:0] a, input logic [63:0] b,
                        input logic h, input logic [63:0] lit, input bit use_lit);
        logic [63:0] exp;
        ra = a; rb = b; half_mode = h;
        exp = use_lit ? lit : model(a, b, h);
        @(negedge clk);
        check64(tag, result, exp);
        check64("R4 carry", {62'h0, carry}, 64'h0);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R8: reset clears result
        check64("R8 reset result", result, 64'h0);
        check64("R4 reset carry", {62'h0, carry}, 64'h0);
        rst_n = 1'b1;

        // R6 identity
        step("R6 identity full", 64'hDEAD_BEEF_0BAD_F00D, 64'h0, 1'b0, 64'hDEAD_BEEF_0BAD_F00D, 1);
        step("R6 identity half", 64'hDEAD_BEEF_0BAD_F00D, 64'h0, 1'b1, 64'h0000_0000_0BAD_F00D, 1);
        // R7 reversal
        step("R7 reverse full", 64'h1, 64'd63, 1'b0, 64'h8000_0000_0000_0000, 1);
        step("R7 reverse half", 64'hFFFF_FFFF_0000_0001, 64'd31, 1'b1, 64'h0000_0000_8000_0000, 1);
        // R1 byte swap (k=56) and nibble swap (k=4)
        step("R1 byte swap", 64'h0102_0304_0506_0708, 64'd56, 1'b0, 64'h0807_0605_0403_0201, 1);
        step("R1 nibble swap", 64'h0123_4567_89AB_CDEF, 64'd4, 1'b0, 64'h1032_5476_98BA_DCFE, 1);
        // R2 half-width halfword swap (k=16)
        step("R2 halfword swap", 64'hAAAA_BBBB_1234_5678, 64'd16, 1'b1, 64'h0000_0000_5678_1234, 1);
        // R5 high rb bits ignored; rb[5] set in half mode, upper half must stay clear (R3)
        step("R5 high rb full", 64'h0102_0304_0506_0708, 64'hFFFF_FFFF_FFFF_FFC0 | 64'd56, 1'b0,
             64'h0807_0605_0403_0201, 1);
        step("R5 R3 rb5 half", 64'hFFFF_0000_1234_5678, 64'h20, 1'b1, 64'h0000_0000_1234_5678, 1);
        step("R5 R3 rb5 half k16", 64'h5555_5555_AAAA_0000, 64'hFFFF_FFFF_FFFF_FFF0, 1'b1,
             64'h0000_0000_0000_AAAA, 1);
        // Back-to-back mode alternation, every cycle compared (R1 R2 R3 R8)
        for (int n = 0; n < 400; n++) begin
            logic [63:0] a;
            logic [63:0] b;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            step(n[0] ? "R2 R3 random half" : "R1 random full", a, b, n[0], 64'h0, 0);
        end
        for (int n = 0; n < 200; n++) begin
            logic [63:0] a;
            a = {$urandom, $urandom};
            step("R1 R2 R5 random mode", a, {$urandom, $urandom}, 1'($urandom), 64'h0, 0);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule